// File: doc/BRIEF.md
# Parallel-Capture Pin Scan Chain

This block gives a memory-style device a reduced boundary-scan path that needs no standard test access port. A single scan-enable level switches the part into scan mode. In that mode a capture/shift select decides what each rising edge of the shift clock does. With the select low, the edge samples the levels of 67 input balls in parallel. With the select high, the edge moves the chain one place toward the serial output. The serial data leaves on a data-strobe pin that the device already has. The block drives an output enable for that pin, and it drives a mode flag that tells functional logic to give the shared pins up.

The chain is fixed in length. Bit 1 is the first bit seen at the output. The stage at the far end is fed with a constant zero, so the output settles to a steady stream of zeros once every captured bit has gone out. The address/command mirror function is forced off while scan is active. Pins are therefore always captured in their unmirrored positions. The board may leave two spare pads of the chain, an extra chip select and a high address bit, unconnected. If it does, the levels captured for them carry no meaning.

Top module: `pinscan_chain`

## Requirements
- R1: A high `rst` at a rising clock edge clears all 67 chain stages and drives `scan_mode_o`, `sdo_oe_o`, `sdo_o` and `mirror_active_o` to 0 after that edge. This holds whatever the level of `scan_en_i`.
- R2: While `scan_en_i` is low at an edge, the chain neither captures nor shifts. After that edge `scan_mode_o` is 0.
- R3: With `scan_en_i`=1 and `shift_sel_i`=0 at an edge, the chain loads `pins_i`, so that chain bit k holds `pins_i[k-1]`. Right after that edge `sdo_o` equals `pins_i[0]`, which is chain bit 1.
- R4: With `scan_en_i`=1 and `shift_sel_i`=1 at an edge, the chain moves one stage toward the output. After n such edges following a capture (1 ≤ n ≤ 66), `sdo_o` equals the captured `pins_i[n]`.
- R5: The last stage shifts in logic 0. After 67 or more shifts following a capture, `sdo_o` is 0.
- R6: `sdo_oe_o` and `scan_mode_o` equal the `scan_en_i` level sampled at the previous edge. `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R7: `mirror_active_o` equals `mirror_i` sampled at the previous edge only when `scan_en_i` was low at that edge. Otherwise it is 0. The bit order of a capture does not depend on `mirror_i`.
- R8: Chain contents survive a period with `scan_en_i` low. When scan returns with a shift, the output continues from the next bit in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| scan_en_i | input | 1 | Scan mode enable level |
| shift_sel_i | input | 1 | 0 = parallel capture, 1 = shift toward output |
| mirror_i | input | 1 | Functional mirror request from board strap |
| pins_i | input | 67 | Unmirrored levels of the scanned balls, bit 0 = chain bit 1 |
| sdo_o | output | 1 | Serial scan data for the shared strobe pin |
| sdo_oe_o | output | 1 | Output enable of the shared strobe pin for scan data |
| scan_mode_o | output | 1 | Tells functional logic to release shared pins |
| mirror_active_o | output | 1 | Mirror function in effect for functional logic |

## Verification
A stage that takes the wrong neighbour or a stuck stage shows up as a wrong serial bit at the exact shift count where that stage reaches the output. The bench therefore compares every one of the 67 bits of several captured patterns, plus the zero tail that follows. Errors in the mode register show up one edge after `scan_en_i` changes, through the output enable, the mode flag or the mirror flag. A chain that does not hold its contents while scan is off is exposed the moment scan resumes, because the bit that then appears at the output is out of order.

// File: rtl/pinscan_pkg.sv
package pinscan_pkg;

  localparam int unsigned CHAIN_LEN_DEF = 67;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } scan_op_e;

endpackage

// File: rtl/pinscan_mode_ctl.sv
module pinscan_mode_ctl
  import pinscan_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scan_en,
  input  logic     shift_sel,
  input  logic     mirror_req,
  output scan_op_e op,
  output logic     scan_mode_q,
  output logic     mirror_act_q
);

  // Action applied to the chain at the coming edge
  always_comb begin
    if (rst || !scan_en) op = OP_HOLD;
    else if (shift_sel)  op = OP_SHIFT;
    else                 op = OP_LOAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_mode_q  <= 1'b0;
      mirror_act_q <= 1'b0;
    end else begin
      scan_mode_q  <= scan_en;
      mirror_act_q <= mirror_req & ~scan_en;
    end
  end

  // R2: scan mode flag drops after an edge with enable low
  p_mode_off_r2: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> !scan_mode_q);

  // R7: mirror never reported while in scan mode
  p_mirror_off_r7: assert property (@(posedge clk) disable iff (rst)
    scan_mode_q |-> !mirror_act_q);

endmodule

// File: rtl/pinscan_shift_reg.sv
module pinscan_shift_reg
  import pinscan_pkg::*;
#(
  parameter int unsigned LEN      = CHAIN_LEN_DEF,
  parameter logic        FILL_BIT = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  scan_op_e       op,
  input  logic [LEN-1:0] par_in,
  output logic           head
);

  localparam int unsigned LAST = LEN - 1;

  logic [LEN-1:0] stage_q;
  logic [LEN-1:0] stage_d;

  // Stage 0 is chain bit 1 and sits next to the output
  for (genvar i = 0; i < LEN; i++) begin : g_stage
    logic from_right;
    if (i == LAST) begin : g_tail
      assign from_right = FILL_BIT;
    end else begin : g_body
      assign from_right = stage_q[i+1];
    end

    always_comb begin
      unique case (op)
        OP_LOAD:  stage_d[i] = par_in[i];
        OP_SHIFT: stage_d[i] = from_right;
        default:  stage_d[i] = stage_q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_d;
  end

  assign head = stage_q[0];

  // R1: reset empties the chain
  p_cleared_r1: assert property (@(posedge clk)
    rst |=> (stage_q == '0));

  // R3: capture takes the parallel pins
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (stage_q == $past(par_in)));

  // R4: one shift advances the head by one stage
  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (stage_q[0] == $past(stage_q[1])));

  // R5: the far end fills with the constant bit
  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (stage_q[LAST] == FILL_BIT));

  // R8: contents stay put while idle
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(stage_q));

endmodule

// File: rtl/pinscan_out_drv.sv
module pinscan_out_drv (
  input  logic scan_mode,
  input  logic head,
  output logic sdo,
  output logic sdo_oe
);

  assign sdo_oe = scan_mode;
  assign sdo    = scan_mode & head;

endmodule

// File: rtl/pinscan_chain.sv
module pinscan_chain
  import pinscan_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = CHAIN_LEN_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_en_i,
  input  logic                 shift_sel_i,
  input  logic                 mirror_i,
  input  logic [CHAIN_LEN-1:0] pins_i,
  output logic                 sdo_o,
  output logic                 sdo_oe_o,
  output logic                 scan_mode_o,
  output logic                 mirror_active_o
);

  scan_op_e op;
  logic     mode_q;
  logic     head;

  pinscan_mode_ctl u_mode (
    .clk          (clk),
    .rst          (rst),
    .scan_en      (scan_en_i),
    .shift_sel    (shift_sel_i),
    .mirror_req   (mirror_i),
    .op           (op),
    .scan_mode_q  (mode_q),
    .mirror_act_q (mirror_active_o)
  );

  pinscan_shift_reg #(
    .LEN      (CHAIN_LEN),
    .FILL_BIT (1'b0)
  ) u_chain (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .par_in (pins_i),
    .head   (head)
  );

  pinscan_out_drv u_out (
    .scan_mode (mode_q),
    .head      (head),
    .sdo       (sdo_o),
    .sdo_oe    (sdo_oe_o)
  );

  assign scan_mode_o = mode_q;

  // R6: strobe pin enable tracks the previous enable level
  p_oe_track_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sdo_oe_o == $past(scan_en_i)));

  // R1: outputs quiet after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!sdo_oe_o && !sdo_o && !scan_mode_o && !mirror_active_o));

endmodule

// File: tb/pinscan_chain_tb_top.sv
module pinscan_chain_tb_top;

  localparam int unsigned LEN = 67;
  localparam int NVEC = 7;
  // bit 67 = mirror_i level, bits 66..0 = pins_i
  localparam logic [LEN:0] VEC [NVEC] = '{
    68'h0_0000_0000_0000_0000,
    68'h7_FFFF_FFFF_FFFF_FFFF,
    68'hD_5555_5555_5555_5555,
    68'h2_AAAA_AAAA_AAAA_AAAA,
    68'h8_0000_0000_0000_0001,
    68'h4_0000_0000_0000_0000,
    68'hB_1234_5678_9ABC_DEF0
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           scan_en_i = 1'b0;
  logic           shift_sel_i = 1'b0;
  logic           mirror_i = 1'b0;
  logic [LEN-1:0] pins_i = '0;
  logic           sdo_o, sdo_oe_o, scan_mode_o, mirror_active_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pinscan_chain #(.CHAIN_LEN(LEN)) dut_i (
    .clk             (clk),
    .rst             (rst),
    .scan_en_i       (scan_en_i),
    .shift_sel_i     (shift_sel_i),
    .mirror_i        (mirror_i),
    .pins_i          (pins_i),
    .sdo_o           (sdo_o),
    .sdo_oe_o        (sdo_oe_o),
    .scan_mode_o     (scan_mode_o),
    .mirror_active_o (mirror_active_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Inputs are set after a falling edge; one rising edge passes before the next falling edge
  task automatic cyc(input logic en, input logic sel);
    scan_en_i   = en;
    shift_sel_i = sel;
    @(negedge clk);
  endtask

  initial begin
    logic [LEN-1:0] p;
    @(negedge clk);
    cyc(1'b0, 1'b0);
    rst = 1'b0;
    // R1: reset state
    check("R1 oe", sdo_oe_o, 1'b0);
    check("R1 sdo", sdo_o, 1'b0);
    check("R1 mode", scan_mode_o, 1'b0);
    check("R1 mirror", mirror_active_o, 1'b0);

    // R2: enable low ignores capture requests
    pins_i = '1;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    check("R2 mode", scan_mode_o, 1'b0);
    check("R2 sdo", sdo_o, 1'b0);
    cyc(1'b1, 1'b1); // first scan action is a shift: chain must still be empty
    check("R2 no_capture", sdo_o, 1'b0);
    check("R6 oe_on", sdo_oe_o, 1'b1);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      p        = VEC[v][LEN-1:0];
      mirror_i = VEC[v][LEN];
      pins_i   = p;
      cyc(1'b1, 1'b0);
      check("R3 bit1", sdo_o, p[0]);
      check("R7 off_in_scan", mirror_active_o, 1'b0);
      check("R6 oe", sdo_oe_o, 1'b1);
      pins_i = ~p; // changes after capture must not matter
      for (int n = 1; n < LEN; n++) begin
        cyc(1'b1, 1'b1);
        check("R4 order", sdo_o, p[n]);
      end
      for (int z = 0; z < 3; z++) begin
        cyc(1'b1, 1'b1);
        check("R5 zeros", sdo_o, 1'b0);
      end
      cyc(1'b0, 1'b1);
      check("R6 oe_off", sdo_oe_o, 1'b0);
      check("R6 sdo_off", sdo_o, 1'b0);
      check("R2 mode_off", scan_mode_o, 1'b0);
      check("R7 follow", mirror_active_o, VEC[v][LEN]);
    end

    // R8: hold across scan disable
    p = VEC[6][LEN-1:0];
    pins_i = p;
    mirror_i = 1'b1;
    cyc(1'b1, 1'b0);
    for (int n = 0; n < 5; n++) cyc(1'b1, 1'b1);
    check("R4 pre_hold", sdo_o, p[5]);
    pins_i = '0;
    for (int n = 0; n < 3; n++) cyc(1'b0, 1'b0);
    check("R7 follow_hold", mirror_active_o, 1'b1);
    cyc(1'b1, 1'b1);
    check("R8 resume", sdo_o, p[6]);
    cyc(1'b1, 1'b1);
    check("R8 resume2", sdo_o, p[7]);

    // R1: reset while scanning clears the chain
    pins_i = '1;
    cyc(1'b1, 1'b0);
    check("R3 ones", sdo_o, 1'b1);
    rst = 1'b1;
    cyc(1'b1, 1'b0);
    check("R1 mid_oe", sdo_oe_o, 1'b0);
    check("R1 mid_sdo", sdo_o, 1'b0);
    rst = 1'b0;
    for (int n = 0; n < 4; n++) begin
      cyc(1'b1, 1'b1);
      check("R1 cleared", sdo_o, 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule